// File: doc/BRIEF.md
# Configurable-Width Half-Rate Serializer

This block turns parallel words of line-coded transmit data into a pair of half-rate serial streams. The words come from an upstream 8b/10b encoder and are already in the local transmit clock domain. On every cycle of the half-rate bit clock the block presents two bits, an even bit and an odd bit. A 2:1 multiplexer outside the block interleaves them into the full-rate line stream. Each half-rate lane is sized for 6.25 Gb/s, so the combined line rate reaches 12.5 Gb/s.

The word width is chosen at run time from 16, 20, 32 or 40 bits. An internal divider counts half-rate cycles and raises a one-cycle word strobe every width/2 cycles. The upstream stage sees this strobe as the ready signal of a ready/valid handshake. When no valid word is offered at the strobe, a fixed idle word goes out in its place. A width change does not disturb the word in flight. The new width is taken up at the next word boundary, or during reset.

Top module: `hrser_top`

## Requirements
- R1: `width_sel` encodes the word width: 2'b00 = 16 bits, 2'b01 = 20 bits, 2'b10 = 32 bits, 2'b11 = 40 bits. Each word occupies width/2 consecutive half-rate cycles (8, 10, 16 or 20).
- R2: Outside reset, `in_ready` is high for exactly one cycle per word. It rises again exactly width/2 cycles after its previous pulse.
- R3: Bits leave LSB first, two at a time. If a word is loaded at clock edge E, then after edge E+k (k = 0 .. width/2-1) `ser_even` equals bit 2k of the word and `ser_odd` equals bit 2k+1.
- R4: The first pair of an accepted word (bits 0 and 1) appears on the outputs right after the edge at which `in_ready` and the word were sampled. No cycle is left empty between words.
- R5: A word is taken from `in_data` only when `in_ready` is high. If `in_valid` is low at that edge, the idle word 40'hA5C396E17B is sent instead, with the same bit order and truncated to the active width. `in_data` and `in_valid` have no effect while `in_ready` is low.
- R6: A new `width_sel` value has no effect on the word being sent. It applies from the next word on.
- R7: While `rst` is high (synchronous, active high), `ser_even`, `ser_odd` and `in_ready` are all zero.
- R8: The divider restarts from zero on reset. `in_ready` is high in the first cycle after `rst` falls, and that first word uses the `width_sel` value present during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate bit clock |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 2 | Word width code (R1) |
| in_data | input | 40 | Parallel encoded word, LSB sent first; bits above the active width are unused |
| in_valid | input | 1 | Upstream word is valid |
| in_ready | output | 1 | One-cycle word strobe; a word is accepted when it is high |
| ser_even | output | 1 | Even bit of the current pair |
| ser_odd | output | 1 | Odd bit of the current pair |

## Verification
A divider that counts to the wrong limit, or latches the width in the middle of a word, moves the next `in_ready` pulse. The bench sees the wrong gap at the very next strobe, and from then on every following pair belongs to the wrong word. A shift register that shifts by the wrong amount, or loads on the wrong edge, corrupts the pair on the second cycle of the word, which is one cycle after the load. An idle word or data-select fault shows up on the first pair of the affected word. The bench therefore compares every pair in every cycle against a queue built from the words it offered, and checks the gap at every strobe.

// File: rtl/hrser_pkg.sv
package hrser_pkg;
  localparam int MAX_W     = 40;
  localparam int MAX_PAIRS = MAX_W / 2;
  localparam int CNT_W     = $clog2(MAX_PAIRS + 1);

  typedef enum logic [1:0] {
    WSEL_16 = 2'b00,
    WSEL_20 = 2'b01,
    WSEL_32 = 2'b10,
    WSEL_40 = 2'b11
  } wsel_e;

  // half-rate cycles spent on one word of the given width
  function automatic logic [CNT_W-1:0] pairs_of(input wsel_e s);
    logic [CNT_W-1:0] p;
    case (s)
      WSEL_16: p = CNT_W'(8);
      WSEL_20: p = CNT_W'(10);
      WSEL_32: p = CNT_W'(16);
      default: p = CNT_W'(20);
    endcase
    return p;
  endfunction
endpackage

// File: rtl/hrser_divider.sv
module hrser_divider
  import hrser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  wsel_e            width_sel,
  output logic             load_o,
  output logic             word_end_o,
  output logic [CNT_W-1:0] pairs_o
);
  logic [CNT_W-1:0] cnt_q;
  wsel_e            act_q;

  assign pairs_o    = pairs_of(act_q);
  assign word_end_o = (cnt_q == pairs_o - CNT_W'(1));
  assign load_o     = !rst && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= width_sel;
    end else if (word_end_o) begin
      cnt_q <= '0;
      act_q <= width_sel;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/hrser_shifter.sv
module hrser_shifter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] sh_o
);
  localparam int STEP = 2;

  always_ff @(posedge clk) begin
    if (rst)       sh_o <= '0;
    else if (load) sh_o <= word_i;
    else           sh_o <= {{STEP{1'b0}}, sh_o[W-1:STEP]};
  end
endmodule

// File: rtl/hrser_top.sv
module hrser_top
  import hrser_pkg::*;
#(
  parameter logic [MAX_W-1:0] IDLE_WORD = 40'hA5C396E17B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       width_sel,
  input  logic [MAX_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             ser_even,
  output logic             ser_odd
);
  logic             load;
  logic             word_end;
  logic [CNT_W-1:0] word_pairs;
  logic [MAX_W-1:0] next_word;
  logic [MAX_W-1:0] sh_q;

  hrser_divider u_div (
    .clk        (clk),
    .rst        (rst),
    .width_sel  (wsel_e'(width_sel)),
    .load_o     (load),
    .word_end_o (word_end),
    .pairs_o    (word_pairs)
  );

  assign next_word = in_valid ? in_data : IDLE_WORD;

  hrser_shifter #(.W(MAX_W)) u_shf (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .word_i (next_word),
    .sh_o   (sh_q)
  );

  assign in_ready = load;
  assign ser_even = sh_q[0];
  assign ser_odd  = sh_q[1];
endmodule

// File: rtl/hrser_checker.sv
module hrser_checker
  import hrser_pkg::*;
#(
  parameter logic [MAX_W-1:0] IDLE_WORD = 40'hA5C396E17B
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             in_valid,
  input logic [MAX_W-1:0] in_data,
  input logic             ser_even,
  input logic             ser_odd,
  input logic             word_end,
  input logic [CNT_W-1:0] pairs,
  input logic [MAX_W-1:0] sh
);
  logic [CNT_W:0]   gap_q;
  logic [CNT_W-1:0] len_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      len_q  <= '0;
      seen_q <= 1'b0;
    end else if (in_ready) begin
      gap_q  <= (CNT_W+1)'(1);
      len_q  <= pairs;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + (CNT_W+1)'(1);
    end
  end

  assert_strobe_period_R2: assert property (@(posedge clk) disable iff (rst)
    (in_ready && seen_q) |-> (gap_q == {1'b0, len_q}));

  assert_strobe_after_end_R2: assert property (@(posedge clk) disable iff (rst)
    word_end |=> in_ready);

  assert_shift_order_R3: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> ({ser_odd, ser_even} == $past(sh[3:2])));

  assert_first_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> ({ser_odd, ser_even} == $past(in_data[1:0])));

  assert_idle_pair_R5: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> ({ser_odd, ser_even} == IDLE_WORD[1:0]));

  assert_width_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !word_end |=> $stable(pairs));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |-> !in_ready);
endmodule

bind hrser_top hrser_checker #(.IDLE_WORD(IDLE_WORD)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .in_valid (in_valid),
  .in_data  (in_data),
  .ser_even (ser_even),
  .ser_odd  (ser_odd),
  .word_end (word_end),
  .pairs    (word_pairs),
  .sh       (sh_q)
);

// File: tb/hrser_top_tb.sv
module hrser_top_tb;
  localparam logic [39:0] IDLE = 40'hA5C396E17B;
  localparam int NCYC = 1500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  width_sel = 2'b10;
  logic [39:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, ser_even, ser_odd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int expq[$];

  always #4 clk = ~clk;

  hrser_top u_dut (
    .clk(clk), .rst(rst), .width_sel(width_sel), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .ser_even(ser_even), .ser_odd(ser_odd)
  );

  function automatic int bench_pairs(input logic [1:0] s);
    int bits;
    bits = s[1] ? 32 : 16;
    if (s[0]) bits = bits + (s[1] ? 8 : 4);
    return bits / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver side: push every pair of the word that will be loaded
  task automatic push_word(input logic [39:0] w, input int np, input bit idle);
    for (int k = 0; k < np; k++)
      expq.push_back(int'(w[2*k +: 2]) | (k << 2) | (int'(idle) << 8));
  endtask

  function automatic bit rst_sched(input int c);
    return (c < 4) || (c >= 700 && c < 703);
  endfunction

  initial begin
    int gap = 0;
    int prev_p = 0;
    bit have_prev = 1'b0;
    int wn = 0;
    bit rst_prev;
    bit released;
    int item;
    int exp_pair;
    logic [39:0] w;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      rst_prev = rst;
      // monitor
      if (rst_prev) begin
        check(!ser_even && !ser_odd && !in_ready, "R7 outputs in reset",
              int'({in_ready, ser_odd, ser_even}), 0);
      end else if (expq.size() == 0) begin
        check(1'b0, "R2 no word queued", 0, 1);
      end else begin
        item = expq.pop_front();
        exp_pair = item & 3;
        if (item[8])
          check({ser_odd, ser_even} == 2'(exp_pair), "R5 idle pair",
                int'({ser_odd, ser_even}), exp_pair);
        else if (((item >> 2) & 63) == 0)
          check({ser_odd, ser_even} == 2'(exp_pair), "R4 first pair",
                int'({ser_odd, ser_even}), exp_pair);
        else
          check({ser_odd, ser_even} == 2'(exp_pair), "R3 pair order",
                int'({ser_odd, ser_even}), exp_pair);
      end
      // reset schedule
      rst = rst_sched(cyc);
      released = rst_prev && !rst;
      if (rst) begin
        expq.delete();
        have_prev = 1'b0;
      end
      #1;
      if (!rst) begin
        gap++;
        if (released) check(in_ready == 1'b1, "R8 strobe after reset", int'(in_ready), 1);
        if (in_ready) begin
          if (have_prev) check(gap == prev_p, "R1 R2 R6 word period", gap, prev_p);
          gap = 0;
          prev_p = bench_pairs(width_sel);
          have_prev = 1'b1;
          if ((wn % 5) == 3) begin
            in_valid = 1'b0;
            in_data = {$urandom, $urandom} [39:0];
            push_word(IDLE, prev_p, 1'b1);
          end else begin
            w = {$urandom, $urandom} [39:0];
            in_valid = 1'b1;
            in_data = w;
            push_word(w, prev_p, 1'b0);
          end
          wn++;
          // new width applies from the next word (R6)
          width_sel = 2'(((wn >> 1) ^ (wn >> 3)) & 3);
        end else begin
          in_valid = 1'($urandom);
          in_data = {$urandom, $urandom} [39:0];
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule